// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the bus master for a three-wire serial EEPROM. A client places a command, an address, write data and an organization flag on a parallel request port and pulses a start strobe. The controller raises chip select, emits the serial frame, and returns read data or completion status. The frame is a start bit, a two-bit op-code and an address, followed by write data for the commands that carry it. The serial clock is derived from the system clock by a parameterized divider. Each command produces exactly the number of serial clocks the memory expects for the selected organization.

For programming commands the controller waits for the memory to finish. It drops chip select for one serial period and then reselects. It then watches the data input for the ready level before reporting done. A cycle limit bounds this wait and flags an error when the memory never becomes ready.

Top module: `uw_eeprom_host`

## Requirements
- R1: Chip select rises only while the serial clock is low. The start bit is already on the data output before the first rising serial edge.
- R2: The controller sends bits MSB first and changes the data output only on falling serial edges. The frame order is: a start bit of 1, then op-code, address and data. The op-codes are READ=10, WRITE=01, ERASE=11, and 00 for the control group. In the control group the two leading address bits select the action: enable=11, disable=00, erase-all=10, write-all=01. The remaining address bits are 0. The cmd_i encoding is 0 READ, 1 WRITE, 2 ERASE, 3 enable, 4 disable, 5 erase-all, 6 write-all, and 7 frames as disable.
- R3: The rising serial edges per frame with org_i=1 / org_i=0 are: WRITE and write-all 25/18; ERASE, enable, disable and erase-all 9/10; READ 26/19.
- R4: With org_i=1 the address is addr_i[5:0] and the data is 16 bits. With org_i=0 the address is addr_i[6:0] and the data is wdata_i[7:0].
- R5: The serial clock idles low. Each half period lasts CLK_DIV system cycles.
- R6: For READ, the controller ignores the bit on the first edge after the address, whatever its value. It then shifts in 16 or 8 bits MSB first. In 8-bit mode the result sits in rdata_o[7:0] and rdata_o[15:8] is 0.
- R7: After WRITE, ERASE, erase-all and write-all, chip select stays low for at least two half periods and then rises with the clock held low. done_o waits until di_i is high.
- R8: If di_i stays low for POLL_LIMIT cycles while polling, err_o is high together with done_o. err_o clears on the next accepted start.
- R9: A start strobe while busy is ignored and produces no frame.
- R10: busy_o rises the cycle after an accepted start and falls after done_o. done_o is a one-cycle pulse. READ and the enable/disable commands finish without polling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe |
| cmd_i | input | 3 | Command code |
| org_i | input | 1 | 1 = 16-bit words, 0 = 8-bit bytes |
| addr_i | input | ADDR_W+1 | Memory address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data |
| done_o | output | 1 | Completion pulse |
| busy_o | output | 1 | Request in progress |
| err_o | output | 1 | Ready wait timed out |
| cs_o | output | 1 | Chip select |
| sclk_o | output | 1 | Serial clock |
| do_o | output | 1 | Serial data to memory |
| di_i | input | 1 | Serial data from memory |

## Verification
The hardest case to reach is the ready-wait timeout, which needs a memory that never finishes. The bench's memory model holds the data line low for a programmable number of cycles after each programming frame. One write sets that hold longer than POLL_LIMIT, and the next command checks that err_o clears. The model also drives a 1 on the read dummy edge, so a controller that captured that edge would return a shifted word.

// File: rtl/uw_pkg.sv
package uw_pkg;
  typedef enum logic [2:0] {
    CMD_READ = 3'd0, CMD_WRITE = 3'd1, CMD_ERASE = 3'd2, CMD_WEN = 3'd3,
    CMD_WDS  = 3'd4, CMD_ERAL  = 3'd5, CMD_WRAL  = 3'd6, CMD_RSVD = 3'd7
  } uw_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SHIFT, ST_GAP, ST_POLL, ST_DONE
  } uw_state_e;

  function automatic logic [1:0] op_of(uw_cmd_e c);
    case (c)
      CMD_READ:  return 2'b10;
      CMD_WRITE: return 2'b01;
      CMD_ERASE: return 2'b11;
      default:   return 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] ctl_code(uw_cmd_e c);
    case (c)
      CMD_WEN:  return 2'b11;
      CMD_ERAL: return 2'b10;
      CMD_WRAL: return 2'b01;
      default:  return 2'b00;
    endcase
  endfunction

  function automatic logic is_prog(uw_cmd_e c);
    return (c == CMD_WRITE) || (c == CMD_ERASE) || (c == CMD_ERAL) || (c == CMD_WRAL);
  endfunction

  function automatic logic has_wdata(uw_cmd_e c);
    return (c == CMD_WRITE) || (c == CMD_WRAL);
  endfunction
endpackage

// File: rtl/uw_tick_gen.sv
module uw_tick_gen #(
  parameter int DIV = 63
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CNT_W'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i || tick_o) cnt_q <= '0;
    else                    cnt_q <= cnt_q + CNT_W'(1);
  end

  AST_DIV_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) <= DIV - 1); // R5
endmodule

// File: rtl/uw_wait_timer.sv
module uw_wait_timer #(
  parameter int LIMIT = 200000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!run_i)     cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + CNT_W'(1);
  end

  AST_TIMER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/uw_frame_build.sv
module uw_frame_build
  import uw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int FW     = 4 + ADDR_W + DATA_W,
  parameter int CW     = $clog2(FW + 1)
) (
  input  logic [2:0]        cmd_i,
  input  logic              org_i,
  input  logic [ADDR_W:0]   addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [FW-1:0]     frame_o,
  output logic [CW-1:0]     total_o,
  output logic [CW-1:0]     hdr_o,
  output logic              prog_o,
  output logic              read_o
);
  localparam int DW8 = DATA_W / 2;

  uw_cmd_e             c;
  logic [1:0]          op;
  logic                ctl;
  logic [ADDR_W-1:0]   a16;
  logic [ADDR_W:0]     a8;
  logic [DATA_W-1:0]   d16;
  logic [DW8-1:0]      d8;
  int                  aw, dw;

  always_comb begin
    c   = uw_cmd_e'(cmd_i);
    op  = op_of(c);
    ctl = (op == 2'b00);
    a16 = ctl ? {ctl_code(c), {(ADDR_W-2){1'b0}}} : addr_i[ADDR_W-1:0];
    a8  = ctl ? {ctl_code(c), {(ADDR_W-1){1'b0}}} : addr_i;
    d16 = has_wdata(c) ? wdata_i : '0;
    d8  = has_wdata(c) ? wdata_i[DW8-1:0] : '0;
    if (org_i) begin
      frame_o = {1'b1, op, a16, d16, 1'b0};
      aw = ADDR_W;
      dw = DATA_W;
    end else begin
      frame_o = {1'b1, op, a8, d8, {DW8{1'b0}}};
      aw = ADDR_W + 1;
      dw = DW8;
    end
    hdr_o = CW'(3 + aw);
    if (has_wdata(c))      total_o = CW'(3 + aw + dw);
    else if (c == CMD_READ) total_o = CW'(4 + aw + dw);
    else                    total_o = CW'(3 + aw);
    prog_o = is_prog(c);
    read_o = (c == CMD_READ);
  end
endmodule

// File: rtl/uw_eeprom_host.sv
module uw_eeprom_host
  import uw_pkg::*;
#(
  parameter int CLK_DIV    = 63,
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int POLL_LIMIT = 200000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        cmd_i,
  input  logic              org_i,
  input  logic [ADDR_W:0]   addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              err_o,
  output logic              cs_o,
  output logic              sclk_o,
  output logic              do_o,
  input  logic              di_i
);
  localparam int FW = 4 + ADDR_W + DATA_W;
  localparam int CW = $clog2(FW + 1);

  uw_state_e         state_q;
  logic [FW-1:0]     frame_q, frame_w;
  logic [CW-1:0]     total_q, total_w, hdr_q, hdr_w, cnt_q;
  logic [DATA_W-1:0] rd_q;
  logic              prog_q, prog_w, read_q, read_w;
  logic              cs_q, sclk_q, err_q, gap_q;
  logic              tick, expired;

  uw_frame_build #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FW(FW), .CW(CW)) u_frame (
    .cmd_i   (cmd_i),
    .org_i   (org_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .frame_o (frame_w),
    .total_o (total_w),
    .hdr_o   (hdr_w),
    .prog_o  (prog_w),
    .read_o  (read_w)
  );

  uw_tick_gen #(.DIV(CLK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   ((state_q == ST_SHIFT) || (state_q == ST_GAP)),
    .tick_o (tick)
  );

  uw_wait_timer #(.LIMIT(POLL_LIMIT)) u_wait (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (state_q == ST_POLL),
    .expired_o (expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      frame_q <= '0;
      total_q <= '0;
      hdr_q   <= '0;
      cnt_q   <= '0;
      rd_q    <= '0;
      prog_q  <= 1'b0;
      read_q  <= 1'b0;
      cs_q    <= 1'b0;
      sclk_q  <= 1'b0;
      err_q   <= 1'b0;
      gap_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          frame_q <= frame_w;
          total_q <= total_w;
          hdr_q   <= hdr_w;
          prog_q  <= prog_w;
          read_q  <= read_w;
          cnt_q   <= '0;
          rd_q    <= '0;
          err_q   <= 1'b0;
          cs_q    <= 1'b1;
          sclk_q  <= 1'b0;
          state_q <= ST_SHIFT;
        end
        ST_SHIFT: if (tick) begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            cnt_q  <= cnt_q + CW'(1);
            // first data edge follows the dummy edge after the address
            if (read_q && ((cnt_q + CW'(1)) >= (hdr_q + CW'(2))))
              rd_q <= {rd_q[DATA_W-2:0], di_i};
          end else begin
            sclk_q <= 1'b0;
            if (cnt_q == total_q) begin
              cs_q    <= 1'b0;
              gap_q   <= 1'b0;
              state_q <= prog_q ? ST_GAP : ST_DONE;
            end else begin
              frame_q <= frame_q << 1;
            end
          end
        end
        ST_GAP: if (tick) begin
          if (gap_q) begin
            cs_q    <= 1'b1;
            state_q <= ST_POLL;
          end else begin
            gap_q <= 1'b1;
          end
        end
        ST_POLL: begin
          if (di_i) begin
            cs_q    <= 1'b0;
            state_q <= ST_DONE;
          end else if (expired) begin
            err_q   <= 1'b1;
            cs_q    <= 1'b0;
            state_q <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_o    = cs_q;
  assign sclk_o  = sclk_q;
  assign do_o    = cs_q & frame_q[FW-1];
  assign rdata_o = rd_q;
  assign err_o   = err_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = (state_q == ST_DONE);

  AST_CS_RISE_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_o) |-> !sclk_o); // R1
  AST_DO_HOLD_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(do_o)); // R2
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= total_q); // R3
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_o |-> !sclk_o); // R5
  AST_POLL_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POLL) |-> !sclk_o); // R7
  AST_POLL_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POLL && di_i) |=> (done_o && !err_o)); // R7
  AST_TIMEOUT_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POLL && !di_i && expired) |=> (done_o && err_o)); // R8
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o); // R10
endmodule

// File: tb/uw_eeprom_host_test.sv
`timescale 1ns/1ps
module uw_eeprom_host_test;
  localparam int DIV = 4;
  localparam int LIM = 200;

  typedef struct {
    int          n_exp;
    int          n_cmp;
    logic [63:0] bits;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  cmd = '0;
  logic        org = 1'b1;
  logic [6:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        done, busy, err, cs, sclk, mosi;
  logic        miso = 1'b1;

  int n_chk = 0, n_bad = 0;
  int frames_seen = 0, issued = 0, cyc = 0;
  int hi_run = 0, hi_min = 1000, hi_max = 0, low_run = 0, last_gap = 0;
  int edge_n = 0, busy_ctr = 0, busy_len = 50;
  bit prog_pend = 0, rd_active = 0, cs_prev = 0, sclk_prev = 0, finished = 0;
  int rd_hdr = 9, rd_dw = 16;
  logic [15:0] rd_data = '0;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  uw_eeprom_host #(.CLK_DIV(DIV), .ADDR_W(6), .DATA_W(16), .POLL_LIMIT(LIM)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_i(cmd), .org_i(org),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .done_o(done), .busy_o(busy),
    .err_o(err), .cs_o(cs), .sclk_o(sclk), .do_o(mosi), .di_i(miso)
  );

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  // serial clock high-time and chip-select low-time measurement (R5, R7)
  always @(posedge clk) begin
    if (sclk) hi_run++;
    else if (hi_run > 0) begin
      if (hi_run < hi_min) hi_min = hi_run;
      if (hi_run > hi_max) hi_max = hi_run;
      hi_run = 0;
    end
    if (!cs) low_run++;
    else begin
      if (low_run > 0) last_gap = low_run;
      low_run = 0;
    end
  end

  // memory model: read data, dummy bit driven as 1, busy hold after programming
  always @(negedge clk) begin
    int e;
    if (cs && sclk && !sclk_prev) edge_n++;
    if (!cs && cs_prev && edge_n > 0 && prog_pend) begin
      busy_ctr = busy_len;
      prog_pend = 0;
    end
    if (!cs) edge_n = 0;
    if (busy_ctr > 0) busy_ctr--;
    e = edge_n + 1;
    if (rd_active) begin
      if (e == rd_hdr + 1) miso = 1'b1;
      else if (e >= rd_hdr + 2 && e <= rd_hdr + 1 + rd_dw) miso = rd_data[rd_dw - 1 - (e - rd_hdr - 2)];
      else miso = 1'b0;
    end else begin
      miso = (busy_ctr == 0);
    end
    cs_prev = cs;
    sclk_prev = sclk;
  end

  // monitor: capture each clocked frame and compare against the scoreboard
  initial begin
    forever begin
      logic [63:0] v;
      int n;
      @(posedge cs);
      chk(sclk == 1'b0, "R1 sclk low at select", 64'(sclk), 64'd0);
      v = '0;
      n = 0;
      while (cs) begin
        @(posedge sclk or negedge cs);
        if (sclk) begin
          v = {v[62:0], mosi};
          n++;
        end
      end
      if (n > 0) begin
        frames_seen++;
        if (exp_q.size() == 0) begin
          chk(0, "R9 unexpected frame", 64'(n), 64'd0);
        end else begin
          exp_t e;
          logic [63:0] got, mask;
          e = exp_q.pop_front();
          chk(n == e.n_exp, "R3 clock count", 64'(n), 64'(e.n_exp));
          mask = (64'd1 << e.n_cmp) - 64'd1;
          got = (n >= e.n_cmp) ? ((v >> (n - e.n_cmp)) & mask) : v;
          chk(got == e.bits, "R2 R4 frame bits", got, e.bits);
        end
      end
    end
  end

  function automatic exp_t mk_exp(int c, bit o, int a, int wd);
    exp_t r;
    int aw, dw;
    logic [1:0] op, code;
    aw = o ? 6 : 7;
    dw = o ? 16 : 8;
    op = (c == 0) ? 2'b10 : (c == 1) ? 2'b01 : (c == 2) ? 2'b11 : 2'b00;
    code = (c == 3) ? 2'b11 : (c == 5) ? 2'b10 : (c == 6) ? 2'b01 : 2'b00;
    r.bits = 64'd1;
    r.bits = {r.bits[61:0], op};
    if (op == 2'b00) begin
      r.bits = {r.bits[61:0], code};
      for (int i = 0; i < aw - 2; i++) r.bits = {r.bits[62:0], 1'b0};
    end else begin
      for (int i = aw - 1; i >= 0; i--) r.bits = {r.bits[62:0], a[i]};
    end
    r.n_cmp = 3 + aw;
    if (c == 1 || c == 6) begin
      for (int i = dw - 1; i >= 0; i--) r.bits = {r.bits[62:0], wd[i]};
      r.n_cmp += dw;
    end
    if (c == 0) r.n_exp = o ? 26 : 19;
    else if (c == 1 || c == 6) r.n_exp = o ? 25 : 18;
    else r.n_exp = o ? 9 : 10;
    return r;
  endfunction

  task automatic run_cmd(int c, bit o, int a, int wd, int rd, int blen, bit exp_err, bit glitch);
    bit prog;
    int waited;
    prog = (c == 1 || c == 2 || c == 5 || c == 6);
    busy_len = blen;
    prog_pend = prog;
    rd_active = (c == 0);
    rd_hdr = o ? 9 : 10;
    rd_dw = o ? 16 : 8;
    rd_data = 16'(rd);
    exp_q.push_back(mk_exp(c, o, a, wd));
    issued++;
    @(negedge clk);
    cmd = 3'(c);
    org = o;
    addr = 7'(a);
    wdata = 16'(wd);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10 busy after start", 64'(busy), 64'd1);
    if (glitch) begin
      repeat (6) @(negedge clk);
      cmd = 3'd0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waited = 0;
    while (!done && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    chk(err == exp_err, "R8 err at done", 64'(err), 64'(exp_err));
    if (c == 0) chk(rdata == 16'(rd), "R6 read data", 64'(rdata), 64'(rd));
    if (prog && !exp_err) begin
      chk(busy_ctr == 0, "R7 done only after ready", 64'(busy_ctr), 64'd0);
      chk(last_gap >= 2 * DIV, "R7 deselect gap", 64'(last_gap), 64'(2 * DIV));
    end
    if (!prog) chk(waited < 40 * 2 * DIV, "R10 no poll phase", 64'(waited), 64'(80 * DIV));
    @(negedge clk);
    chk(!done && !busy, "R10 done pulse one cycle", {62'd0, done, busy}, 64'd0);
    chk(frames_seen == issued, "R9 frame count", 64'(frames_seen), 64'(issued));
    rd_active = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({cs, sclk, busy, done, err} == 5'b0, "R5 R10 reset state", 64'({cs, sclk, busy, done, err}), 64'd0);

    run_cmd(3, 1, 0, 0, 0, 50, 0, 0);          // enable x16, R2 R3
    run_cmd(1, 1, 'h2A, 'hBEEF, 0, 50, 0, 0);  // write x16, R4 R7
    run_cmd(0, 1, 'h2A, 0, 'hBEEF, 50, 0, 0);  // read x16, R6
    run_cmd(3, 0, 0, 0, 0, 50, 0, 0);          // enable x8
    run_cmd(1, 0, 'h55, 'hA5, 0, 50, 0, 0);    // write x8, R4
    run_cmd(0, 0, 'h55, 0, 'h3C, 50, 0, 0);    // read x8, R6 upper byte 0
    run_cmd(2, 1, 'h11, 0, 0, 30, 0, 0);       // erase x16
    run_cmd(5, 0, 0, 0, 0, 40, 0, 0);          // erase-all x8
    run_cmd(6, 1, 0, 'h1234, 0, 60, 0, 0);     // write-all x16
    run_cmd(4, 1, 0, 0, 0, 50, 0, 0);          // disable x16
    run_cmd(1, 1, 'h07, 'h0F0F, 0, 1000, 1, 0); // R8 timeout
    while (busy_ctr > 0) @(negedge clk);
    run_cmd(4, 0, 0, 0, 0, 50, 0, 0);          // R8 err cleared
    run_cmd(3, 1, 0, 0, 0, 50, 0, 1);          // R9 strobe while busy
    run_cmd(0, 1, 'h3F, 0, 'h8001, 50, 0, 0);  // read edge pattern

    chk(hi_min == DIV && hi_max == DIV, "R5 half period", 64'(hi_max), 64'(DIV));
    chk(exp_q.size() == 0, "R3 scoreboard drained", 64'(exp_q.size()), 64'd0);
    finished = 1;
    summary();
  end
endmodule